// File: doc/BRIEF.md
# Call, Return and Jump Sequencer

This block holds the program counter of an 8-bit controller with a 16-bit program space, along with the 8-bit stack pointer that sits in internal RAM. Each cycle it is idle, the decoder may present one control-flow operation. The operation carries its length in bytes, a branch kind, and any operands it needs: an 11-bit in-page target, a 16-bit far target, a signed 8-bit displacement, the accumulator, the data pointer, and a taken flag for conditional branches. The block then moves the PC to the matching destination.

Calls save the address of the next instruction by writing two bytes through a single-byte RAM port. The stack pointer is incremented before each byte is stored, and the low byte goes first. Returns read the two bytes back, high byte first, decrementing the pointer after each read. The interrupt form of return also produces a one-cycle release strobe for the interrupt controller. Plain branches finish in one cycle. Calls and returns hold `busy` for two further cycles, and any operation offered during that time is dropped.

Top module: `flow_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block loads PC 0x0000 and SP 0x07. In the cycle after that edge, `busy`, `ram_we`, `ram_re` and `irq_release` are all low.
- R2: When idle with `issue` high, kind 0 (sequential), and kind 1 (conditional) with `taken` low, both set PC to PC + `ins_len` modulo 2^16 at the next edge.
- R3: Kind 2 (short jump), and kind 1 with `taken` high, set PC to (PC + `ins_len`) + sign-extended `rel_off` modulo 2^16. This gives a reach of -128 to +127 from the following instruction.
- R4: Kind 3 (page jump) keeps bits 15..11 of PC + `ins_len` and replaces bits 10..0 with `page_addr`. A branch whose next address falls in the following 2 KB page therefore lands in that page.
- R5: Kind 4 (far jump) loads PC with `far_addr` at the next edge.
- R6: Kind 5 (indirect) loads PC with `dptr` plus the zero-extended `acc` modulo 2^16.
- R7: Kind 6 (page call) and kind 7 (far call) push the return address PC + `ins_len` in two consecutive cycles. The first cycle writes the low byte at SP+1 and the second writes the high byte at SP+2. SP ends 2 higher, and PC takes the kind 3 or kind 4 destination at the end of the second write cycle. `ram_we` and `ram_re` are never high together.
- R8: Kind 8 (return) reads the high byte at SP and then the low byte at SP-1 in two consecutive cycles. `ram_rdata` is taken in the cycle of each read. SP ends 2 lower, and PC becomes {high, low} at the end of the second read.
- R9: Kind 9 (interrupt return) behaves like kind 8 and also raises `irq_release` for exactly one cycle, during its second read. Kind 8 never raises `irq_release`.
- R10: An operation presented while `busy` is high has no effect on PC, SP or the RAM strobes. With `issue` low and the block idle, PC and SP hold.
- R11: SP arithmetic wraps modulo 256 and changes only in cycles with a RAM strobe. Returns starting from SP 0x07 reach 0xFF after four pops, and a call from there writes RAM 0x00 and 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | An operation is presented this cycle |
| br_kind | input | 4 | Branch kind code, 0..9 as listed in the requirements; other codes act as kind 0 |
| ins_len | input | 2 | Length of the current instruction in bytes |
| taken | input | 1 | Condition result for kind 1 |
| page_addr | input | 11 | In-page target for kinds 3 and 6 |
| far_addr | input | 16 | Full target for kinds 4 and 7 |
| rel_off | input | 8 | Signed displacement for kinds 1 and 2 |
| acc | input | 8 | Accumulator value for kind 5 |
| dptr | input | 16 | Data pointer value for kind 5 |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | A push or pop sequence is in progress |
| ram_we | output | 1 | Byte write strobe to internal RAM |
| ram_re | output | 1 | Byte read strobe to internal RAM |
| ram_addr | output | 8 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid in the cycle of the read |
| irq_release | output | 1 | One-cycle strobe letting the serviced interrupt level be accepted again |

## Verification
A fresh operation can arrive in the same cycle that a push or pop sequence writes or reads its final byte and loads the PC. The bench provokes this by holding a far jump on `issue` through every busy cycle of a call, including the final one. It then judges the outcome from the ports alone: PC must equal the call destination, SP must be exactly two higher, and no extra strobe may follow. The stack end and the reload also coincide when a call is followed at once by a return, and the bench checks that the restored PC is the saved return address.

// File: rtl/flow_pkg.sv
// Shared types for the control-flow sequencer.
// Assumes branch kinds arrive as a 4-bit code and unknown codes act as sequential.
package flow_pkg;

    typedef enum logic [3:0] {
        K_SEQ      = 4'd0,
        K_COND     = 4'd1,
        K_SHORT    = 4'd2,
        K_PAGE     = 4'd3,
        K_FAR      = 4'd4,
        K_INDIR    = 4'd5,
        K_PAGECALL = 4'd6,
        K_FARCALL  = 4'd7,
        K_RET      = 4'd8,
        K_RETI     = 4'd9
    } br_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_POP_HI,
        ST_POP_LO
    } stk_state_e;

    // True for kinds that save a return address
    function automatic logic is_call(br_kind_e k);
        return (k == K_PAGECALL) || (k == K_FARCALL);
    endfunction

    // True for kinds that restore a return address
    function automatic logic is_return(br_kind_e k);
        return (k == K_RET) || (k == K_RETI);
    endfunction

endpackage

// File: rtl/target_calc.sv
// Combinational destination calculator.
// Works out the address after the current instruction and the destination for
// every branch kind except returns, whose destination comes from the stack.
// Assumes ADDR_W > PAGE_W, ADDR_W > OFF_W and ADDR_W > DATA_W.
module target_calc
    import flow_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 11,
    parameter int OFF_W  = 8,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2
) (
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [LEN_W-1:0]  len,
    input  logic [3:0]        kind_raw,
    input  logic              taken,
    input  logic [PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0] far,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] acc,
    input  logic [ADDR_W-1:0] dptr,
    output logic [ADDR_W-1:0] next_seq,
    output logic [ADDR_W-1:0] target
);

    localparam int OFF_EXT = ADDR_W - OFF_W;
    localparam int ACC_EXT = ADDR_W - DATA_W;

    br_kind_e          kind;
    logic [ADDR_W-1:0] rel_dest;
    logic [ADDR_W-1:0] page_dest;
    logic [ADDR_W-1:0] indir_dest;

    assign kind = br_kind_e'(kind_raw);

    // Address of the following instruction and the three computed destinations
    always_comb begin
        next_seq   = cur_pc + ADDR_W'(len);
        rel_dest   = next_seq + {{OFF_EXT{off[OFF_W-1]}}, off};
        page_dest  = {next_seq[ADDR_W-1:PAGE_W], page};
        indir_dest = dptr + {{ACC_EXT{1'b0}}, acc};
    end

    // Pick the destination by kind
    always_comb begin
        case (kind)
            K_COND:                target = taken ? rel_dest : next_seq;
            K_SHORT:               target = rel_dest;
            K_PAGE, K_PAGECALL:    target = page_dest;
            K_FAR, K_FARCALL:      target = far;
            K_INDIR:               target = indir_dest;
            default:               target = next_seq;
        endcase
    end

endmodule

// File: rtl/stack_engine.sv
// Stack pointer and two-byte push/pop sequencer.
// A push increments SP before each byte store, low byte first. A pop reads
// the high byte at SP, then the low byte, decrementing SP after each read.
// Assumes the RAM returns read data in the same cycle as the read strobe, and
// that start requests are only raised while idle.
module stack_engine
    import flow_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          SP_W     = 8,
    parameter logic [7:0]  SP_RESET = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_call,
    input  logic              start_ret,
    input  logic              start_reti,
    input  logic [ADDR_W-1:0] save_addr,
    input  logic [ADDR_W-1:0] call_dest,
    output logic              busy,
    output logic [SP_W-1:0]   sp,
    output logic              ram_we,
    output logic              ram_re,
    output logic [SP_W-1:0]   ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              load_pc,
    output logic [ADDR_W-1:0] load_val,
    output logic              release_strobe
);

    localparam logic [SP_W-1:0] SP_ONE  = SP_W'(1);
    localparam int              HI_LSB  = ADDR_W - DATA_W;

    stk_state_e        state;
    logic [ADDR_W-1:0] saved_q;
    logic [ADDR_W-1:0] dest_q;
    logic [DATA_W-1:0] hi_q;
    logic              reti_q;
    logic              pushing;

    // Sequence state, stack pointer and latched operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sp      <= SP_RESET[SP_W-1:0];
            saved_q <= '0;
            dest_q  <= '0;
            hi_q    <= '0;
            reti_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_call) begin
                        saved_q <= save_addr;
                        dest_q  <= call_dest;
                        state   <= ST_PUSH_LO;
                    end else if (start_ret) begin
                        reti_q  <= start_reti;
                        state   <= ST_POP_HI;
                    end
                end
                ST_PUSH_LO: begin
                    sp    <= sp + SP_ONE;
                    state <= ST_PUSH_HI;
                end
                ST_PUSH_HI: begin
                    sp    <= sp + SP_ONE;
                    state <= ST_IDLE;
                end
                ST_POP_HI: begin
                    hi_q  <= ram_rdata;
                    sp    <= sp - SP_ONE;
                    state <= ST_POP_LO;
                end
                ST_POP_LO: begin
                    sp    <= sp - SP_ONE;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // RAM strobes, address and write byte for the current step
    always_comb begin
        pushing   = (state == ST_PUSH_LO) || (state == ST_PUSH_HI);
        ram_we    = pushing;
        ram_re    = (state == ST_POP_HI) || (state == ST_POP_LO);
        ram_addr  = pushing ? (sp + SP_ONE) : sp;
        ram_wdata = (state == ST_PUSH_LO) ? saved_q[DATA_W-1:0]
                                          : saved_q[ADDR_W-1:HI_LSB];
    end

    // PC reload at the last step of a sequence, plus the release strobe
    always_comb begin
        busy           = (state != ST_IDLE);
        load_pc        = (state == ST_PUSH_HI) || (state == ST_POP_LO);
        load_val       = (state == ST_PUSH_HI) ? dest_q : {hi_q, ram_rdata};
        release_strobe = (state == ST_POP_LO) && reti_q;
    end

endmodule

// File: rtl/flow_sequencer.sv
// Top of the call, return and jump sequencer.
// Owns the program counter. Plain branches update it in one cycle, and calls
// and returns hand off to the stack engine, which reloads it at the end.
// Assumes ADDR_W is exactly two RAM bytes wide.
module flow_sequencer
    import flow_pkg::*;
#(
    parameter int         ADDR_W   = 16,
    parameter int         PAGE_W   = 11,
    parameter int         OFF_W    = 8,
    parameter int         DATA_W   = 8,
    parameter int         LEN_W    = 2,
    parameter int         SP_W     = 8,
    parameter logic [7:0] SP_RESET = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [3:0]        br_kind,
    input  logic [LEN_W-1:0]  ins_len,
    input  logic              taken,
    input  logic [PAGE_W-1:0] page_addr,
    input  logic [ADDR_W-1:0] far_addr,
    input  logic [OFF_W-1:0]  rel_off,
    input  logic [DATA_W-1:0] acc,
    input  logic [ADDR_W-1:0] dptr,
    output logic [ADDR_W-1:0] pc,
    output logic [SP_W-1:0]   sp,
    output logic              busy,
    output logic              ram_we,
    output logic              ram_re,
    output logic [SP_W-1:0]   ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              irq_release
);

    br_kind_e          kind;
    logic              accept;
    logic              go_call;
    logic              go_ret;
    logic [ADDR_W-1:0] next_seq;
    logic [ADDR_W-1:0] dest;
    logic              eng_load;
    logic [ADDR_W-1:0] eng_val;

    assign kind    = br_kind_e'(br_kind);
    assign accept  = issue && !busy;
    assign go_call = accept && is_call(kind);
    assign go_ret  = accept && is_return(kind);

    target_calc #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_calc (
        .cur_pc   (pc),
        .len      (ins_len),
        .kind_raw (br_kind),
        .taken    (taken),
        .page     (page_addr),
        .far      (far_addr),
        .off      (rel_off),
        .acc      (acc),
        .dptr     (dptr),
        .next_seq (next_seq),
        .target   (dest)
    );

    stack_engine #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SP_W     (SP_W),
        .SP_RESET (SP_RESET)
    ) u_stack (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_call     (go_call),
        .start_ret      (go_ret),
        .start_reti     (kind == K_RETI),
        .save_addr      (next_seq),
        .call_dest      (dest),
        .busy           (busy),
        .sp             (sp),
        .ram_we         (ram_we),
        .ram_re         (ram_re),
        .ram_addr       (ram_addr),
        .ram_wdata      (ram_wdata),
        .ram_rdata      (ram_rdata),
        .load_pc        (eng_load),
        .load_val       (eng_val),
        .release_strobe (irq_release)
    );

    // Program counter: direct branch update or reload from the stack engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (eng_load) begin
            pc <= eng_val;
        end else if (accept && !is_call(kind) && !is_return(kind)) begin
            pc <= dest;
        end
    end

endmodule

// File: rtl/flow_sequencer_chk.sv
// Property checker for the sequencer, attached by bind.
// Observes ports only.
module flow_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        issue,
    input logic [3:0]  br_kind,
    input logic [15:0] far_addr,
    input logic [15:0] pc,
    input logic [7:0]  sp,
    input logic        busy,
    input logic        ram_we,
    input logic        ram_re,
    input logic        irq_release
);

    // Reset state seen one cycle after a reset edge
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (pc == 16'h0000 && sp == 8'h07 && !busy && !ram_we && !ram_re && !irq_release)); // R1

    // Far jump lands on the presented address
    AST_FAR_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !busy && br_kind == 4'd4) |=> pc == $past(far_addr)); // R5

    // Each write step raises SP by one
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> sp == 8'($past(sp) + 8'd1)); // R7

    // Never a write and a read together
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re)); // R7

    // Each read step lowers SP by one
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |=> sp == 8'($past(sp) - 8'd1)); // R8

    // Release strobe only during a stack read
    AST_RELEASE_IN_POP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_release |-> ram_re); // R9

    // Idle with nothing presented: PC and SP hold
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !issue) |=> ($stable(pc) && $stable(sp))); // R10

    // SP moves only with a RAM strobe
    AST_SP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_we && !ram_re) |=> $stable(sp)); // R11

endmodule

bind flow_sequencer flow_sequencer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue       (issue),
    .br_kind     (br_kind),
    .far_addr    (far_addr),
    .pc          (pc),
    .sp          (sp),
    .busy        (busy),
    .ram_we      (ram_we),
    .ram_re      (ram_re),
    .irq_release (irq_release)
);

// File: tb/flow_sequencer_test.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module flow_sequencer_test;

    localparam int CLK_PERIOD = 10;

    localparam int KSEQ = 0, KCOND = 1, KSHORT = 2, KPAGE = 3, KFAR = 4,
                   KINDIR = 5, KPCALL = 6, KFCALL = 7, KRET = 8, KRETI = 9;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue;
    logic [3:0]  br_kind;
    logic [1:0]  ins_len;
    logic        taken;
    logic [10:0] page_addr;
    logic [15:0] far_addr;
    logic [7:0]  rel_off;
    logic [7:0]  acc;
    logic [15:0] dptr;
    logic [15:0] pc;
    logic [7:0]  sp;
    logic        busy;
    logic        ram_we;
    logic        ram_re;
    logic [7:0]  ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata;
    logic        irq_release;

    int tests = 0;
    int fails = 0;
    int rel_count = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    flow_sequencer uut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .br_kind(br_kind),
        .ins_len(ins_len), .taken(taken), .page_addr(page_addr),
        .far_addr(far_addr), .rel_off(rel_off), .acc(acc), .dptr(dptr),
        .pc(pc), .sp(sp), .busy(busy), .ram_we(ram_we), .ram_re(ram_re),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .irq_release(irq_release)
    );

    // Bench RAM that the design talks to
    logic [7:0] bmem [256];
    assign ram_rdata = bmem[ram_addr];
    always @(posedge clk) if (ram_we) bmem[ram_addr] <= ram_wdata;

    // Reference model: own RAM image, PC, SP and a queue of pending stack steps
    // step codes: 1 = push byte, 2 = final push byte, 3 = pop high, 4 = final pop
    logic [7:0]  rmem [256];
    int          q[$];
    logic [15:0] m_pc, m_dest;
    logic [7:0]  m_sp, m_hi;
    bit          m_reti;

    initial begin
        for (int i = 0; i < 256; i++) begin
            bmem[i] = 8'h00;
            rmem[i] = 8'h00;
        end
    end

    always @(posedge clk) begin
        int          op;
        logic [15:0] nxt;
        logic [15:0] rel;
        if (!rst_n) begin
            m_pc = 16'h0000; m_sp = 8'h07; q.delete();
        end else if (q.size() > 0) begin
            op = q.pop_front();
            case (op >> 8)
                1: begin m_sp = m_sp + 8'd1; rmem[m_sp] = op[7:0]; end
                2: begin m_sp = m_sp + 8'd1; rmem[m_sp] = op[7:0]; m_pc = m_dest; end
                3: begin m_hi = rmem[m_sp]; m_sp = m_sp - 8'd1; end
                default: begin m_pc = {m_hi, rmem[m_sp]}; m_sp = m_sp - 8'd1; end
            endcase
        end else if (issue) begin
            nxt = m_pc + 16'(ins_len);
            rel = nxt + {{8{rel_off[7]}}, rel_off};
            case (int'(br_kind))
                KCOND:  m_pc = taken ? rel : nxt;
                KSHORT: m_pc = rel;
                KPAGE:  m_pc = {nxt[15:11], page_addr};
                KFAR:   m_pc = far_addr;
                KINDIR: m_pc = dptr + {8'h00, acc};
                KPCALL, KFCALL: begin
                    m_dest = (int'(br_kind) == KPCALL) ? {nxt[15:11], page_addr} : far_addr;
                    q.push_back(32'h100 | int'(nxt[7:0]));
                    q.push_back(32'h200 | int'(nxt[15:8]));
                end
                KRET, KRETI: begin
                    m_reti = (int'(br_kind) == KRETI);
                    q.push_back(32'h300);
                    q.push_back(32'h400);
                end
                default: m_pc = nxt;
            endcase
        end
    end

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Compare every observable port against the model
    task automatic compare_all();
        int  head;
        bit  e_we, e_re, e_rel;
        head  = (q.size() > 0) ? q[0] : 0;
        e_we  = ((head >> 8) == 1) || ((head >> 8) == 2);
        e_re  = ((head >> 8) == 3) || ((head >> 8) == 4);
        e_rel = ((head >> 8) == 4) && m_reti;
        check(cur_req, "pc", pc, m_pc);
        check(cur_req, "sp", sp, m_sp);
        check(cur_req, "busy", busy, (q.size() > 0));
        check(cur_req, "ram_we", ram_we, e_we);
        check(cur_req, "ram_re", ram_re, e_re);
        check("R9", "irq_release", irq_release, e_rel);
        if (e_we) begin
            check(cur_req, "write addr", ram_addr, 8'(m_sp + 8'd1));
            check(cur_req, "write data", ram_wdata, head & 255);
        end
        if (e_re) check(cur_req, "read addr", ram_addr, m_sp);
        if (irq_release) rel_count++;
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic go(int k, int l, int fa, int pg, int of, int a, int dp, bit tk);
        br_kind = 4'(k); ins_len = 2'(l); far_addr = 16'(fa); page_addr = 11'(pg);
        rel_off = 8'(of); acc = 8'(a); dptr = 16'(dp); taken = tk;
        issue = 1'b1;
        step();
        issue = 1'b0;
        while (q.size() > 0) step();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; issue = 1'b0; br_kind = 4'd0; ins_len = 2'd0; taken = 1'b0;
        page_addr = '0; far_addr = '0; rel_off = '0; acc = '0; dptr = '0;
        repeat (3) step();
        rst_n = 1'b1;
        // R1: reset state
        check("R1", "pc after reset", pc, 16'h0000);
        check("R1", "sp after reset", sp, 8'h07);
        check("R1", "busy after reset", busy, 0);

        cur_req = "R5";
        go(KFAR, 3, 16'h0230, 0, 0, 0, 0, 0);
        check("R5", "far jump pc", pc, 16'h0230);

        cur_req = "R7";
        go(KPCALL, 2, 0, 11'h567, 0, 0, 0, 0);
        check("R7", "page call pc", pc, 16'h0567);
        check("R7", "sp after call", sp, 8'h09);
        check("R7", "low byte at 0x08", bmem[8], 8'h32);
        check("R7", "high byte at 0x09", bmem[9], 8'h02);

        cur_req = "R8";
        go(KRET, 1, 0, 0, 0, 0, 0, 0);
        check("R8", "return pc", pc, 16'h0232);
        check("R8", "sp after return", sp, 8'h07);
        check("R9", "no release on plain return", rel_count, 0);

        cur_req = "R2";
        go(KSEQ, 1, 0, 0, 0, 0, 0, 0);
        check("R2", "sequential pc", pc, 16'h0233);
        go(KCOND, 3, 0, 0, 8'h10, 0, 0, 0);
        check("R2", "not-taken pc", pc, 16'h0236);

        cur_req = "R3";
        go(KCOND, 2, 0, 0, 8'hF0, 0, 0, 1);
        check("R3", "taken backward pc", pc, 16'h0228);
        go(KFAR, 3, 16'h0100, 0, 0, 0, 0, 0);
        go(KSHORT, 2, 0, 0, 8'h1E, 0, 0, 0);
        check("R3", "short forward pc", pc, 16'h0120);
        go(KSHORT, 2, 0, 0, 8'h80, 0, 0, 0);
        check("R3", "short -128 pc", pc, 16'h00A2);
        go(KFAR, 3, 16'hFFFE, 0, 0, 0, 0, 0);
        go(KSHORT, 2, 0, 0, 8'h05, 0, 0, 0);
        check("R3", "short wrap pc", pc, 16'h0005);

        cur_req = "R4";
        go(KFAR, 3, 16'h07FF, 0, 0, 0, 0, 0);
        go(KPAGE, 2, 0, 11'h123, 0, 0, 0, 0);
        check("R4", "page jump across boundary", pc, 16'h0923);

        cur_req = "R6";
        go(KINDIR, 1, 0, 0, 0, 8'h20, 16'hFFF0, 0);
        check("R6", "indirect wrap pc", pc, 16'h0010);
        go(KINDIR, 1, 0, 0, 0, 8'hFF, 16'h1234, 0);
        check("R6", "indirect pc", pc, 16'h1333);

        cur_req = "R7";
        go(KFCALL, 3, 16'hABCD, 0, 0, 0, 0, 0);
        check("R7", "far call pc", pc, 16'hABCD);
        check("R7", "far call low byte", bmem[8], 8'h36);
        check("R7", "far call high byte", bmem[9], 8'h13);

        cur_req = "R9";
        go(KRETI, 1, 0, 0, 0, 0, 0, 0);
        check("R9", "interrupt return pc", pc, 16'h1336);
        check("R9", "release pulses", rel_count, 1);

        // R10: far jump held on issue through every busy cycle of a call
        cur_req = "R10";
        br_kind = 4'(KPCALL); ins_len = 2'd2; page_addr = 11'h055;
        issue = 1'b1;
        step();
        br_kind = 4'(KFAR); far_addr = 16'h7777; ins_len = 2'd3;
        step();
        step();
        issue = 1'b0;
        step();
        check("R10", "pc after ignored jump", pc, 16'h1055);
        check("R10", "sp after ignored jump", sp, 8'h09);
        check("R10", "no strobe after sequence", ram_we | ram_re, 0);
        go(KRET, 1, 0, 0, 0, 0, 0, 0);
        check("R10", "return after ignored jump", pc, 16'h1338);
        repeat (2) step();
        check("R10", "idle pc hold", pc, 16'h1338);

        // R11: pops below zero wrap, then a call writes at 0x00 and 0x01
        cur_req = "R11";
        repeat (4) go(KRET, 1, 0, 0, 0, 0, 0, 0);
        check("R11", "sp wrapped", sp, 8'hFF);
        go(KFAR, 3, 16'h4321, 0, 0, 0, 0, 0);
        go(KFCALL, 3, 16'h0400, 0, 0, 0, 0, 0);
        check("R11", "sp after wrapped call", sp, 8'h01);
        check("R11", "low byte at 0x00", bmem[0], 8'h24);
        check("R11", "high byte at 0x01", bmem[1], 8'h43);

        repeat (2) step();
        finish_run();
    end

endmodule